// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector

This block watches a one-bit serial stream and raises a flag whenever the three most recent bits, taken at successive rising clock edges, were 1, then 0, then 1. The flag is a registered Moore output. It stays high for exactly one clock period, the period that begins at the edge which sampled the closing 1. Detection overlaps: the closing 1 of one match can open the next.

The state register holds four one-hot flip-flops: idle, seen 1, seen 1-0, and match. The next-state logic is written as explicit equations over these bits. A state vector that is not one-hot returns to idle on the next edge. An active-low asynchronous reset forces the idle state and clears the flag.

Top module: `seq101_detector`

## Requirements
- R1: When x_i samples 1, 0, 1 at three consecutive rising edges, y_o is 1 during the period that follows the third of those edges and 0 in the period after it, unless a further match completes at that edge.
- R2: y_o changes only at a rising clock edge or on reset. Toggling x_i between edges leaves y_o unchanged.
- R3: Out of reset, exactly one bit of the four-bit state vector is set at all times.
- R4: Detection overlaps. The stream 1,0,1,0,1 produces two one-cycle pulses on y_o, two cycles apart.
- R5: A repeated 1 keeps the partial match, so 1,1,0,1 produces a detection. Two zeros discard it, so 1,0,0,1 does not.
- R6: While rst_ni is 0, y_o is 0 at once, without waiting for a clock edge. Reset also discards any partial match, so a 1 applied right after release does not complete a 1,0 that was seen before reset.
- R7: For the stream 0,1,1,0,1,1,1,0,1,0,0,1,0,1,0 applied in periods 1 to 15 after reset, y_o is 1 in periods 6, 10 and 15 and 0 in every other period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; x_i is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial data bit |
| y_o | output | 1 | Registered detect flag, high for one period after each 1-0-1 |

## Verification
On every cycle, the assertions check three things: that the state vector stays one-hot, that a completed 1-0 followed by a 1 always raises the flag, and that the flag is only ever high when the two preceding samples were 1 and 0. No two flags can be adjacent. The asynchronous reset, the flag's insensitivity to x_i between edges, and the loss of a partial match across reset can only be shown by the bench's directed scenarios. So can the overlap between matches and the full reference stream.

// File: rtl/seq101_pkg.sv
package seq101_pkg;
  localparam int NUM_ST = 4;
  // one-hot bit positions
  localparam int ST_IDLE = 0;
  localparam int ST_ONE  = 1;
  localparam int ST_ONEZ = 2;
  localparam int ST_HIT  = 3;
  typedef logic [NUM_ST-1:0] st_vec_t;
  localparam st_vec_t ST_RESET = st_vec_t'(1) << ST_IDLE;
endpackage

// File: rtl/seq101_next.sv
module seq101_next
  import seq101_pkg::*;
(
  input  st_vec_t st_i,
  input  logic    x_i,
  output st_vec_t nxt_o
);
  logic legal;

  always_comb begin
    legal = ($countones(st_i) == 1);
    nxt_o = '0;
    nxt_o[ST_IDLE] = !legal | (!x_i & (st_i[ST_IDLE] | st_i[ST_ONEZ]));
    nxt_o[ST_ONE]  = legal & x_i & (st_i[ST_IDLE] | st_i[ST_ONE] | st_i[ST_HIT]);
    nxt_o[ST_ONEZ] = legal & !x_i & (st_i[ST_ONE] | st_i[ST_HIT]);
    nxt_o[ST_HIT]  = legal & x_i & st_i[ST_ONEZ];
  end
endmodule

// File: rtl/seq101_state_reg.sv
module seq101_state_reg
  import seq101_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  st_vec_t nxt_i,
  output st_vec_t st_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= ST_RESET;
    else         st_o <= nxt_i;
  end

  // R3
  onehot_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_o) == 1);
endmodule

// File: rtl/seq101_detector.sv
module seq101_detector
  import seq101_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic y_o
);
  st_vec_t st_q, st_d;

  seq101_next u_next (
    .st_i  (st_q),
    .x_i   (x_i),
    .nxt_o (st_d)
  );

  seq101_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (st_d),
    .st_o   (st_q)
  );

  // Moore output straight from the match flop
  assign y_o = st_q[ST_HIT];

  // R1
  detect_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_ONEZ] && x_i) |=> y_o);

  // R1
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_o |=> !y_o);

  // R5
  hit_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_o |-> ($past(x_i) && !$past(x_i, 2)));
endmodule

// File: tb/seq101_detector_bench.sv
module seq101_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  localparam logic [NVEC-1:0] VEC_X = 15'b0_1_1_0_1_1_1_0_1_0_0_1_0_1_0;
  localparam logic [NVEC-1:0] VEC_Y = 15'b0_0_0_0_0_1_0_0_0_1_0_0_0_0_1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic y;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq101_detector u_seq101_detector (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .x_i    (x),
    .y_o    (y)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: y_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // drive a bit, cross one rising edge, land on the falling edge
  task automatic tick(input logic xv);
    x = xv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    x = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: y_o=%b expected completion", y);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(y, 1'b0, "R6 reset state");
    do_reset();

    // R7 reference stream, also R1
    for (int k = 0; k < NVEC; k++) begin
      chk(y, VEC_Y[NVEC-1-k], $sformatf("R7 period %0d", k + 1));
      tick(VEC_X[NVEC-1-k]);
    end

    // R4 overlap
    do_reset();
    tick(1'b1); chk(y, 1'b0, "R4 after 1");
    tick(1'b0); chk(y, 1'b0, "R4 after 10");
    tick(1'b1); chk(y, 1'b1, "R1 first match");
    tick(1'b0); chk(y, 1'b0, "R1 pulse one cycle");
    tick(1'b1); chk(y, 1'b1, "R4 overlapped match");

    // R2 x toggling between edges
    x = 1'b0; #(CLK_PERIOD/8);
    chk(y, 1'b1, "R2 x low mid-cycle");
    x = 1'b1; #(CLK_PERIOD/8);
    chk(y, 1'b1, "R2 x high mid-cycle");

    // R6 asynchronous clear while flag high
    rst_n = 1'b0; #1;
    chk(y, 1'b0, "R6 async clear");
    @(negedge clk);
    rst_n = 1'b1;

    // R5 repeated 1 keeps partial match
    tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b1);
    chk(y, 1'b1, "R5 1101 detects");
    // R5 double zero drops it
    do_reset();
    tick(1'b1); tick(1'b0); tick(1'b0); tick(1'b1);
    chk(y, 1'b0, "R5 1001 no detect");

    // R6 partial match lost across reset
    do_reset();
    tick(1'b1); tick(1'b0);
    do_reset();
    tick(1'b1);
    chk(y, 1'b0, "R6 no residual match");
    tick(1'b0); tick(1'b1);
    chk(y, 1'b1, "R1 detects after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule